// File: doc/BRIEF.md
# Interrupt Acknowledge with Three-Level Return Stack

This block decides when a small controller takes an external interrupt and keeps the return addresses for it. It samples an interrupt pin once per instruction clock. A falling edge counts as a request only when the pin then stays low for a minimum number of samples, two by default. A request is taken when software has set the interrupt-enable bit and the current instruction has signalled completion. A request that arrives before completion is held pending. A request that arrives while the enable bit is clear is thrown away.

Taking an interrupt does three things in one clock edge. The address after the current one is pushed into a three-register return chain, and the oldest entry falls off the end. The program counter is told to load the fixed vector 0x0FF. The enable bit is cleared, so that software must set it again before another interrupt can be taken. A pop request, issued by the return instruction, sends the top entry back to the program counter and moves the chain up by one. The bottom level keeps its value.

Top module: `irq_ret_stack`

## Requirements
- R1: An interrupt is accepted only in a cycle where the enable bit is 1, `instr_done` is 1, and a qualified request is present, either pending or qualifying in that same cycle.
- R2: A request qualifies on the clock edge that makes the second consecutive low sample of `irq_pin`, counted after at least one high sample. A low of one sample is ignored. Each low pulse gives at most one request, and a new pulse needs a new high sample first.
- R3: On acceptance, `stk_a` becomes `pc_cur`+1, `stk_b` takes the old `stk_a`, `stk_c` takes the old `stk_b`, and the old `stk_c` is lost.
- R4: On the edge after acceptance, `pc_load` is 1 for one cycle and `pc_next` is 0x0FF. While `pc_load` is 0, `pc_next` keeps its last loaded value.
- R5: Acceptance clears the enable bit, even when `ie_set` is high in the same cycle. In any other cycle, `ie_set` sets the enable bit.
- R6: A request that qualifies while the enable bit is 0 is discarded, and setting the bit later does not revive it.
- R7: A request that qualifies while `instr_done` is 0 stays pending, across any number of cycles, until the first cycle with `instr_done` equal to 1.
- R8: A pop, taken when no acceptance happens in that cycle, gives `pc_load`=1 and `pc_next`=old `stk_a` on the next edge. It also moves `stk_b` to `stk_a` and `stk_c` to `stk_b`, and leaves `stk_c` unchanged.
- R9: `pc_cur`+1 wraps within 10 bits, so 0x3FF pushes 0x000.
- R10: Synchronous reset clears the enable bit, the pending request, the pulse qualifier, all stack levels, `pc_next` and `pc_load`.
- R11: When acceptance and `ret_pop` fall in the same cycle, the acceptance is performed and the pop is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Instruction clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_done | input | 1 | Current instruction completes this cycle |
| pc_cur | input | 10 | Address of the executing instruction |
| irq_pin | input | 1 | External interrupt pin, active low pulse |
| ie_set | input | 1 | Request to set the interrupt-enable bit |
| ret_pop | input | 1 | Return request: pop the stack into the PC |
| pc_next | output | 10 | Value the PC must load |
| pc_load | output | 1 | PC load strobe, one cycle |
| ie_q | output | 1 | Interrupt-enable bit |
| stk_a | output | 10 | Stack level A (top) |
| stk_b | output | 10 | Stack level B |
| stk_c | output | 10 | Stack level C (bottom) |

## Verification
Two situations are the hardest to reach from the ports. One is a pulse that qualifies while the enable bit is clear and must leave no trace. The other is a pending request that must not survive a reset. For the first, the stimulus runs a complete low pulse with the enable bit clear, sets the bit while the pin is still low, and holds `instr_done` high for several cycles to show that no load follows. For the second, a request is made pending with `instr_done` low, reset is applied, the bit is set again with the pin held high, and `instr_done` is raised to confirm that no load occurs. Overflow of the chain is reached by three acceptances without a pop followed by a fourth acceptance, and the pops that follow show which entry was dropped.

// File: rtl/irqstk_pkg.sv
package irqstk_pkg;

    localparam int unsigned PC_W_DEF    = 10;
    localparam int unsigned VEC_DEF     = 'h0FF;
    localparam int unsigned LOW_MIN_DEF = 2;
    localparam int unsigned LEVELS_DEF  = 3;

    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_op_e;

endpackage

// File: rtl/irqstk_pulse_qual.sv
module irqstk_pulse_qual #(
    parameter int unsigned LOW_MIN = irqstk_pkg::LOW_MIN_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic qual
);
    localparam int unsigned CW = $clog2(LOW_MIN + 1);

    logic          armed_q;
    logic [CW-1:0] low_cnt_q;

    // a pulse qualifies on the sample that completes LOW_MIN low samples
    assign qual = armed_q && !pin && (low_cnt_q == CW'(LOW_MIN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q   <= 1'b0;
            low_cnt_q <= '0;
        end else if (pin) begin
            armed_q   <= 1'b1;
            low_cnt_q <= '0;
        end else if (qual) begin
            armed_q   <= 1'b0;
            low_cnt_q <= '0;
        end else if (armed_q) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/irqstk_lifo.sv
module irqstk_lifo #(
    parameter int unsigned W      = irqstk_pkg::PC_W_DEF,
    parameter int unsigned LEVELS = irqstk_pkg::LEVELS_DEF
) (
    input  logic                        clk,
    input  logic                        rst,
    input  irqstk_pkg::stk_op_e         op,
    input  logic [W-1:0]                push_val,
    output logic [LEVELS-1:0][W-1:0]    lvl_q
);
    import irqstk_pkg::*;

    for (genvar i = 0; i < LEVELS; i++) begin : g_lvl
        logic [W-1:0] from_above;
        logic [W-1:0] from_below;

        if (i == 0) begin : g_top
            assign from_above = push_val;
        end else begin : g_mid
            assign from_above = lvl_q[i-1];
        end

        if (i == LEVELS - 1) begin : g_bot
            assign from_below = lvl_q[i];      // bottom level holds on pop
        end else begin : g_up
            assign from_below = lvl_q[i+1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                lvl_q[i] <= '0;
            end else begin
                case (op)
                    STK_PUSH: lvl_q[i] <= from_above;
                    STK_POP:  lvl_q[i] <= from_below;
                    default:  lvl_q[i] <= lvl_q[i];
                endcase
            end
        end
    end
endmodule

// File: rtl/irqstk_accept_ctl.sv
module irqstk_accept_ctl #(
    parameter int unsigned     W      = irqstk_pkg::PC_W_DEF,
    parameter logic [W-1:0]    VECTOR = W'(irqstk_pkg::VEC_DEF)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 qual,
    input  logic                 instr_done,
    input  logic                 ie_set,
    input  logic                 ret_pop,
    input  logic [W-1:0]         pc_cur,
    input  logic [W-1:0]         stk_top,
    output logic                 ie_q,
    output logic                 acc,
    output irqstk_pkg::stk_op_e  op,
    output logic [W-1:0]         push_val,
    output logic [W-1:0]         pc_next,
    output logic                 pc_load
);
    import irqstk_pkg::*;

    logic pend_q;

    assign acc      = ie_q && instr_done && (pend_q || qual);
    assign push_val = pc_cur + W'(1);

    always_comb begin
        if (acc)          op = STK_PUSH;
        else if (ret_pop) op = STK_POP;
        else              op = STK_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q    <= 1'b0;
            pend_q  <= 1'b0;
            pc_next <= '0;
            pc_load <= 1'b0;
        end else begin
            if (acc)         ie_q <= 1'b0;
            else if (ie_set) ie_q <= 1'b1;

            if (acc)               pend_q <= 1'b0;
            else if (qual && ie_q) pend_q <= 1'b1;

            pc_load <= acc || ret_pop;
            if (acc)          pc_next <= VECTOR;
            else if (ret_pop) pc_next <= stk_top;
        end
    end
endmodule

// File: rtl/irq_ret_stack.sv
module irq_ret_stack #(
    parameter int unsigned        PC_W    = irqstk_pkg::PC_W_DEF,
    parameter logic [PC_W-1:0]    VECTOR  = PC_W'(irqstk_pkg::VEC_DEF),
    parameter int unsigned        LOW_MIN = irqstk_pkg::LOW_MIN_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            instr_done,
    input  logic [PC_W-1:0] pc_cur,
    input  logic            irq_pin,
    input  logic            ie_set,
    input  logic            ret_pop,
    output logic [PC_W-1:0] pc_next,
    output logic            pc_load,
    output logic            ie_q,
    output logic [PC_W-1:0] stk_a,
    output logic [PC_W-1:0] stk_b,
    output logic [PC_W-1:0] stk_c
);
    import irqstk_pkg::*;

    localparam int unsigned LEVELS = 3;

    logic                          qual;
    logic                          acc;
    stk_op_e                       op;
    logic [PC_W-1:0]               push_val;
    logic [LEVELS-1:0][PC_W-1:0]   lvl_q;

    irqstk_pulse_qual #(.LOW_MIN(LOW_MIN)) u_qual (
        .clk  (clk),
        .rst  (rst),
        .pin  (irq_pin),
        .qual (qual)
    );

    irqstk_accept_ctl #(.W(PC_W), .VECTOR(VECTOR)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .qual       (qual),
        .instr_done (instr_done),
        .ie_set     (ie_set),
        .ret_pop    (ret_pop),
        .pc_cur     (pc_cur),
        .stk_top    (lvl_q[0]),
        .ie_q       (ie_q),
        .acc        (acc),
        .op         (op),
        .push_val   (push_val),
        .pc_next    (pc_next),
        .pc_load    (pc_load)
    );

    irqstk_lifo #(.W(PC_W), .LEVELS(LEVELS)) u_lifo (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .push_val (push_val),
        .lvl_q    (lvl_q)
    );

    assign stk_a = lvl_q[0];
    assign stk_b = lvl_q[1];
    assign stk_c = lvl_q[2];
endmodule

// File: rtl/irqstk_chk.sv
module irqstk_chk #(
    parameter int unsigned     PC_W   = 10,
    parameter logic [PC_W-1:0] VECTOR = 10'h0FF
) (
    input logic            clk,
    input logic            rst,
    input logic            instr_done,
    input logic [PC_W-1:0] pc_cur,
    input logic            ret_pop,
    input logic            acc,
    input logic [PC_W-1:0] pc_next,
    input logic            pc_load,
    input logic            ie_q,
    input logic [PC_W-1:0] stk_a,
    input logic [PC_W-1:0] stk_b,
    input logic [PC_W-1:0] stk_c
);
    AST_ACC_GATED: assert property (@(posedge clk) disable iff (rst)
        acc |-> (ie_q && instr_done)); // R1

    AST_PUSH_CHAIN: assert property (@(posedge clk) disable iff (rst)
        acc |=> (stk_a == $past(pc_cur) + PC_W'(1)) && (stk_b == $past(stk_a))
                && (stk_c == $past(stk_b))); // R3

    AST_VECTOR_LOAD: assert property (@(posedge clk) disable iff (rst)
        acc |=> (pc_load && pc_next == VECTOR)); // R4

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!acc && !ret_pop) |=> (!pc_load && $stable(pc_next))); // R4

    AST_IE_DROPS: assert property (@(posedge clk) disable iff (rst)
        acc |=> !ie_q); // R5

    AST_POP_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (ret_pop && !acc) |=> (pc_load && pc_next == $past(stk_a)
            && stk_a == $past(stk_b) && stk_b == $past(stk_c)
            && $stable(stk_c))); // R8

    AST_POP_YIELDS: assert property (@(posedge clk) disable iff (rst)
        (ret_pop && acc) |=> (pc_next == VECTOR && stk_b == $past(stk_a))); // R11

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!ie_q && !pc_load && stk_a == '0 && stk_b == '0
                 && stk_c == '0 && pc_next == '0)); // R10
endmodule

bind irq_ret_stack irqstk_chk #(.PC_W(PC_W), .VECTOR(VECTOR)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .instr_done (instr_done),
    .pc_cur     (pc_cur),
    .ret_pop    (ret_pop),
    .acc        (acc),
    .pc_next    (pc_next),
    .pc_load    (pc_load),
    .ie_q       (ie_q),
    .stk_a      (stk_a),
    .stk_b      (stk_b),
    .stk_c      (stk_c)
);

// File: tb/sim_irq_ret_stack.sv
`timescale 1ns/1ps
module sim_irq_ret_stack;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       instr_done = 1'b0;
    logic [9:0] pc_cur = '0;
    logic       irq_pin = 1'b0;
    logic       ie_set = 1'b0;
    logic       ret_pop = 1'b0;
    logic [9:0] pc_next;
    logic       pc_load;
    logic       ie_q;
    logic [9:0] stk_a, stk_b, stk_c;

    int checks = 0;
    int fails  = 0;
    bit done_run = 1'b0;

    always #2.5 clk = ~clk;

    irq_ret_stack u0 (
        .clk(clk), .rst(rst), .instr_done(instr_done), .pc_cur(pc_cur),
        .irq_pin(irq_pin), .ie_set(ie_set), .ret_pop(ret_pop),
        .pc_next(pc_next), .pc_load(pc_load), .ie_q(ie_q),
        .stk_a(stk_a), .stk_b(stk_b), .stk_c(stk_c)
    );

    typedef struct packed {
        logic       pin;
        logic       done;
        logic       ies;
        logic       pop;
        logic [9:0] pc;
        logic       eld;
        logic [9:0] epc;
        logic       eie;
        logic [9:0] ea;
        logic [9:0] eb;
        logic [9:0] ec;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1,0,1,0,10'h010, 0,10'h000,1,10'h000,10'h000,10'h000},
        '{0,0,0,0,10'h010, 0,10'h000,1,10'h000,10'h000,10'h000},
        '{0,0,0,0,10'h010, 0,10'h000,1,10'h000,10'h000,10'h000},
        '{0,1,0,0,10'h123, 1,10'h0FF,0,10'h124,10'h000,10'h000},
        '{1,1,1,0,10'h0FF, 0,10'h0FF,1,10'h124,10'h000,10'h000},
        '{0,1,0,0,10'h200, 0,10'h0FF,1,10'h124,10'h000,10'h000},
        '{0,1,0,0,10'h201, 1,10'h0FF,0,10'h202,10'h124,10'h000},
        '{1,0,1,0,10'h000, 0,10'h0FF,1,10'h202,10'h124,10'h000},
        '{0,0,0,0,10'h000, 0,10'h0FF,1,10'h202,10'h124,10'h000},
        '{0,1,0,0,10'h3FF, 1,10'h0FF,0,10'h000,10'h202,10'h124},
        '{1,0,1,0,10'h000, 0,10'h0FF,1,10'h000,10'h202,10'h124},
        '{0,0,0,0,10'h000, 0,10'h0FF,1,10'h000,10'h202,10'h124},
        '{0,1,0,0,10'h050, 1,10'h0FF,0,10'h051,10'h000,10'h202},
        '{1,0,0,1,10'h000, 1,10'h051,0,10'h000,10'h202,10'h202},
        '{1,0,0,1,10'h000, 1,10'h000,0,10'h202,10'h202,10'h202},
        '{0,0,0,0,10'h000, 0,10'h000,0,10'h202,10'h202,10'h202},
        '{0,1,0,0,10'h000, 0,10'h000,0,10'h202,10'h202,10'h202},
        '{0,1,1,0,10'h000, 0,10'h000,1,10'h202,10'h202,10'h202},
        '{0,1,0,0,10'h000, 0,10'h000,1,10'h202,10'h202,10'h202},
        '{1,0,0,1,10'h000, 1,10'h202,1,10'h202,10'h202,10'h202},
        '{0,1,0,0,10'h000, 0,10'h202,1,10'h202,10'h202,10'h202},
        '{1,1,0,0,10'h000, 0,10'h202,1,10'h202,10'h202,10'h202},
        '{0,1,0,0,10'h0AA, 0,10'h202,1,10'h202,10'h202,10'h202},
        '{0,1,1,1,10'h0AA, 1,10'h0FF,0,10'h0AB,10'h202,10'h202}
    };

    function automatic string req_of(int i);
        case (i)
            0, 1, 2:  return "R1 R7";
            3:        return "R7 R3 R4 R5";
            4, 5, 6:  return "R1 R2 R3";
            7, 8:     return "R5 R2";
            9:        return "R9 R3";
            10, 11:   return "R4";
            12:       return "R3";
            13, 14:   return "R8";
            15, 16, 17, 18: return "R6";
            19:       return "R8";
            20, 21:   return "R2";
            default:  return "R11 R5";
        endcase
    endfunction

    task automatic drive(input logic p, input logic d, input logic s,
                         input logic r, input logic [9:0] pc);
        irq_pin = p; instr_done = d; ie_set = s; ret_pop = r; pc_cur = pc;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [41:0] act,
                         input logic [41:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (ld,pc_next,ie,a,b,c)",
                     tag, act, exp);
        end
    endtask

    function automatic logic [41:0] outs();
        return {pc_load, pc_next, ie_q, stk_a, stk_b, stk_c};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // r10_ initial reset state
        check("R10 reset state", outs(), 42'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].pin, VECS[i].done, VECS[i].ies, VECS[i].pop, VECS[i].pc);
            check(req_of(i), outs(),
                  {VECS[i].eld, VECS[i].epc, VECS[i].eie,
                   VECS[i].ea, VECS[i].eb, VECS[i].ec});
        end

        // R7: pending held across several busy cycles
        drive(1, 0, 1, 0, 10'h000);
        drive(0, 0, 0, 0, 10'h000);
        drive(0, 0, 0, 0, 10'h000);
        drive(1, 0, 0, 0, 10'h000);
        drive(1, 0, 0, 0, 10'h000);
        check("R7 pending waits", {pc_load, ie_q}, 2'b01);
        drive(1, 1, 0, 0, 10'h3FE);
        check("R7 pending taken", outs(),
              {1'b1, 10'h0FF, 1'b0, 10'h3FF, 10'h0AB, 10'h202});

        // R10: reset wipes a pending request
        drive(1, 0, 1, 0, 10'h000);
        drive(0, 0, 0, 0, 10'h000);
        drive(0, 0, 0, 0, 10'h000);
        rst = 1'b1;
        drive(1, 0, 0, 0, 10'h000);
        drive(1, 0, 0, 0, 10'h000);
        check("R10 reset clears", outs(), 42'h0);
        rst = 1'b0;
        drive(1, 0, 1, 0, 10'h000);
        drive(1, 1, 0, 0, 10'h040);
        drive(1, 1, 0, 0, 10'h041);
        check("R10 no stale pending", outs(),
              {1'b0, 10'h000, 1'b1, 10'h000, 10'h000, 10'h000});

        // R2: a pulse held low for long gives only one request
        drive(0, 0, 0, 0, 10'h000);
        drive(0, 1, 0, 0, 10'h100);
        check("R2 long pulse accepted", {pc_load, ie_q, stk_a}, {2'b10, 10'h101});
        drive(0, 1, 1, 0, 10'h0FF);
        drive(0, 1, 0, 0, 10'h0FF);
        drive(0, 1, 0, 0, 10'h0FF);
        check("R2 one request per pulse", {pc_load, ie_q, stk_a}, {2'b01, 10'h101});

        done_run = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done_run) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule